// File: doc/BRIEF.md
# Seeded Fractional-N Noise-Shaping Modulator

This block produces, once per reference cycle, the divide value for a fractional-N feedback divider. The value is an integer base plus a small signed offset. The offset comes from a third-order cascade of three first-order accumulators, with noise shaping. Each accumulator wraps modulo a programmable modulus. Over time the offsets average to the fraction word divided by the modulus.

A load strobe captures the base integer, fraction, modulus, seed word and dither enable. It also places the modulator in a known state: the first accumulator starts from the seed word reduced modulo the modulus, and every other state element is cleared. For a given fraction and seed, the quantization error sequence is therefore the same after every load. This lets system software pick the seed that gives the smallest error on a particular later cycle.

An optional dither source is a 23-bit shift-register sequence. It is restarted from a fixed value on each load, and it adds one pseudo-random unit into the first stage, which breaks up the periodic pattern.

Top module: `fracn_sdm`

## Requirements
- R1: After reset, and until the first load, `n_out` is 0 and stays 0.
- R2: On the clock edge where `load` is sampled high, the block captures `int_word`, `frac`, `modulus`, `phase` and `dither_en`. On the next cycle `n_out` equals the captured `int_word`, because the output is seeded with the bare integer.
- R3: On each later edge with `load` low, the block advances one step. Stage 1 adds the fraction plus the dither bit to its accumulator. Stage k>1 adds stage k-1's new residue. A stage carries when its sum is at least the modulus, and the modulus is then subtracted. The output becomes INT + c1 + (c2 − c2') + (c3 − 2·c3' + c3''), where the primes mark carries from one and two steps earlier. Those earlier carries count as 0 right after a load.
- R4: The first accumulator is seeded with `phase` modulo `modulus`. A seed and the same seed plus the modulus give identical sequences.
- R5: Reloading the same configuration reproduces the same output sequence exactly.
- R6: With fraction 0, seed 0 and dither off, `n_out` equals INT on every cycle.
- R7: Every output after a load lies in the range INT−3 to INT+4. INT must be at least 3.
- R8: With dither off, over any run of L steps after a load, the sum S of the offsets satisfies |S·MOD − L·FRAC| < 4·MOD.
- R9: When the captured dither enable is 1, bit 22 of the LFSR is added into stage 1 on each step. The LFSR holds 0x2A5A5 after a load and shifts left with feedback bit22 XOR bit17. It advances on every step.
- R10: Changes on the configuration inputs while `load` is low have no effect on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load | input | 1 | Capture configuration and seed the modulator |
| int_word | input | INT_W | Integer part of the divide ratio |
| frac | input | MOD_W | Fraction numerator, less than `modulus` |
| modulus | input | MOD_W | Fraction denominator, nonzero |
| phase | input | MOD_W | Seed word for the first accumulator |
| dither_en | input | 1 | Enable the pseudo-random first-stage unit |
| n_out | output | INT_W+1 | Divide value for the current cycle |

## Verification
The core check sweeps every fraction for moduli 5, 7 and 16. Each fraction is run with seeds of 0, modulus−1 and a value above the modulus. Each cycle is compared with an arithmetic model, which separates errors in the carry compare, the wrap subtraction, the seed reduction and the combiner delays. Tests comparing two sequences tell apart seeds that differ by exactly the modulus and an exact reload. A dithered run is matched against the model and also required to differ from its undithered twin. A large modulus near the 12-bit limit checks the long-run average bound. While each sequence runs, the configuration inputs are scrambled, so any leak from the live inputs shows up as a mismatch.

// File: rtl/fracn_sdm_pkg.sv
package fracn_sdm_pkg;
  localparam int unsigned LFSR_W    = 23;
  localparam int unsigned LFSR_TAP  = 18;
  localparam logic [LFSR_W-1:0] LFSR_SEED = 23'h02A5A5;
  localparam int unsigned STAGES    = 3;
  localparam int unsigned OFS_W     = 4;
  typedef logic signed [OFS_W-1:0] mash_ofs_t;
endpackage

// File: rtl/fracn_sdm_stage.sv
module fracn_sdm_stage #(
  parameter int unsigned W = 12
) (
  input  logic [W-1:0] acc_q,
  input  logic [W-1:0] addend,
  input  logic         cin,
  input  logic [W-1:0] modulus,
  output logic [W-1:0] acc_nx,
  output logic         carry
);
  logic [W:0] sum_w;
  logic [W:0] wrap_w;

  always_comb begin
    sum_w  = {1'b0, acc_q} + {1'b0, addend} + {{W{1'b0}}, cin};
    carry  = (sum_w >= {1'b0, modulus});
    wrap_w = sum_w - {1'b0, modulus};
    acc_nx = carry ? wrap_w[W-1:0] : sum_w[W-1:0];
  end
endmodule

// File: rtl/fracn_sdm_lfsr.sv
module fracn_sdm_lfsr
  import fracn_sdm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic reseed,
  input  logic en,
  output logic bit_o
);
  logic [LFSR_W-1:0] q, d;

  always_comb begin
    d = q;
    if (reseed)  d = LFSR_SEED;
    else if (en) d = {q[LFSR_W-2:0], q[LFSR_W-1] ^ q[LFSR_TAP-1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= LFSR_SEED;
    else        q <= d;
  end

  assign bit_o = q[LFSR_W-1];
endmodule

// File: rtl/fracn_sdm_comb.sv
module fracn_sdm_comb
  import fracn_sdm_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic                    en,
  input  logic [STAGES-1:0]       carry,
  output mash_ofs_t               ofs
);
  logic c2_d, c3_d, c3_dd;
  logic c2_dn, c3_dn, c3_ddn;

  always_comb begin
    c2_dn  = c2_d;
    c3_dn  = c3_d;
    c3_ddn = c3_dd;
    if (clr) begin
      c2_dn  = 1'b0;
      c3_dn  = 1'b0;
      c3_ddn = 1'b0;
    end else if (en) begin
      c2_dn  = carry[1];
      c3_dn  = carry[2];
      c3_ddn = c3_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c2_d  <= 1'b0;
      c3_d  <= 1'b0;
      c3_dd <= 1'b0;
    end else begin
      c2_d  <= c2_dn;
      c3_d  <= c3_dn;
      c3_dd <= c3_ddn;
    end
  end

  always_comb begin
    ofs = $signed({3'b000, carry[0]})
        + $signed({3'b000, carry[1]}) - $signed({3'b000, c2_d})
        + $signed({3'b000, carry[2]}) - $signed({2'b00, c3_d, 1'b0})
        + $signed({3'b000, c3_dd});
  end
endmodule

// File: rtl/fracn_sdm.sv
module fracn_sdm
  import fracn_sdm_pkg::*;
#(
  parameter int unsigned MOD_W = 12,
  parameter int unsigned INT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [INT_W-1:0] int_word,
  input  logic [MOD_W-1:0] frac,
  input  logic [MOD_W-1:0] modulus,
  input  logic [MOD_W-1:0] phase,
  input  logic             dither_en,
  output logic [INT_W:0]   n_out
);
  localparam int unsigned OUT_W = INT_W + 1;
  localparam int unsigned SUM_W = OUT_W + 2;

  // reset release synchronizer
  logic [1:0] rs_q;
  logic       rst_q_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_q_n = rs_q[1];

  // captured configuration
  logic [INT_W-1:0] int_q, int_d;
  logic [MOD_W-1:0] frac_q, frac_d, mod_q, mod_d;
  logic             dith_q, dith_d;
  logic             run_q, run_d;
  logic             adv;
  logic [MOD_W-1:0] seed;

  assign adv  = run_q & ~load;
  assign seed = (modulus == '0) ? '0 : (phase % modulus);

  always_comb begin
    int_d  = int_q;
    frac_d = frac_q;
    mod_d  = mod_q;
    dith_d = dith_q;
    run_d  = run_q;
    if (load) begin
      int_d  = int_word;
      frac_d = frac;
      mod_d  = modulus;
      dith_d = dither_en;
      run_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      int_q  <= '0;
      frac_q <= '0;
      mod_q  <= '0;
      dith_q <= 1'b0;
      run_q  <= 1'b0;
    end else begin
      int_q  <= int_d;
      frac_q <= frac_d;
      mod_q  <= mod_d;
      dith_q <= dith_d;
      run_q  <= run_d;
    end
  end

  // dither source
  logic lfsr_bit, dith_bit;
  fracn_sdm_lfsr u_lfsr (
    .clk    (clk),
    .rst_n  (rst_q_n),
    .reseed (load),
    .en     (adv),
    .bit_o  (lfsr_bit)
  );
  assign dith_bit = lfsr_bit & dith_q;

  // accumulator cascade
  logic [MOD_W-1:0]  acc_q [STAGES];
  logic [MOD_W-1:0]  acc_d [STAGES];
  logic [STAGES-1:0] carry;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    logic [MOD_W-1:0] addend;
    logic [MOD_W-1:0] nx;
    logic             cin;
    logic             cy;
    if (i == 0) begin : g_first
      assign addend = frac_q;
      assign cin    = dith_bit;
      assign acc_d[i] = load ? seed : (adv ? nx : acc_q[i]);
    end else begin : g_next
      assign addend = g_stage[i-1].nx;
      assign cin    = 1'b0;
      assign acc_d[i] = load ? '0 : (adv ? nx : acc_q[i]);
    end
    fracn_sdm_stage #(.W(MOD_W)) u_stage (
      .acc_q   (acc_q[i]),
      .addend  (addend),
      .cin     (cin),
      .modulus (mod_q),
      .acc_nx  (nx),
      .carry   (cy)
    );
    assign carry[i] = cy;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      for (int k = 0; k < STAGES; k++) acc_q[k] <= '0;
    end else begin
      for (int k = 0; k < STAGES; k++) acc_q[k] <= acc_d[k];
    end
  end

  // noise-shaping combiner
  mash_ofs_t ofs;
  fracn_sdm_comb u_comb (
    .clk   (clk),
    .rst_n (rst_q_n),
    .clr   (load),
    .en    (adv),
    .carry (carry),
    .ofs   (ofs)
  );

  // output register
  logic signed [SUM_W-1:0] sum_w;
  logic [OUT_W-1:0]        n_d, n_q;

  always_comb begin
    sum_w = $signed({3'b000, int_q}) + $signed({{(SUM_W-OFS_W){ofs[OFS_W-1]}}, ofs});
    n_d   = n_q;
    if (load)     n_d = {1'b0, int_word};
    else if (adv) n_d = sum_w[OUT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) n_q <= '0;
    else          n_q <= n_d;
  end

  assign n_out = n_q;
endmodule

// File: rtl/fracn_sdm_chk.sv
module fracn_sdm_chk #(
  parameter int unsigned MOD_W = 12,
  parameter int unsigned INT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             load,
  input logic             run_q,
  input logic [INT_W-1:0] int_word,
  input logic [INT_W-1:0] int_q,
  input logic [MOD_W-1:0] phase,
  input logic [MOD_W-1:0] modulus,
  input logic [MOD_W-1:0] frac_q,
  input logic [MOD_W-1:0] mod_q,
  input logic [MOD_W-1:0] acc0,
  input logic [INT_W:0]   n_out
);
  p_idle_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> (n_out == '0));

  p_load_int_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (n_out == {1'b0, $past(int_word)}));

  p_seed_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (load && modulus != '0) |=> (acc0 == ($past(phase) % $past(modulus))));

  p_acc_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && mod_q != '0) |-> (acc0 < mod_q));

  p_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !load) |=> ((int'(n_out) >= int'(int_q) - 3) &&
                          (int'(n_out) <= int'(int_q) + 4)));

  p_cfg_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(frac_q) && $stable(mod_q) && $stable(int_q)));
endmodule

bind fracn_sdm fracn_sdm_chk #(.MOD_W(MOD_W), .INT_W(INT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_q_n),
  .load     (load),
  .run_q    (run_q),
  .int_word (int_word),
  .int_q    (int_q),
  .phase    (phase),
  .modulus  (modulus),
  .frac_q   (frac_q),
  .mod_q    (mod_q),
  .acc0     (acc_q[0]),
  .n_out    (n_out)
);

// File: tb/fracn_sdm_test.sv
module fracn_sdm_test;
  localparam int CLK_PERIOD = 10;
  localparam int MOD_W = 12;
  localparam int INT_W = 8;
  localparam int MAXLEN = 512;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             load;
  logic [INT_W-1:0] int_word;
  logic [MOD_W-1:0] frac, modulus, phase;
  logic             dither_en;
  logic [INT_W:0]   n_out;

  int tests = 0;
  int fails = 0;
  int seq_a [MAXLEN];
  int seq_b [MAXLEN];
  int last_seq [MAXLEN];

  always #(CLK_PERIOD/2) clk = ~clk;

  fracn_sdm #(.MOD_W(MOD_W), .INT_W(INT_W)) uut (
    .clk(clk), .rst_n(rst_n), .load(load), .int_word(int_word),
    .frac(frac), .modulus(modulus), .phase(phase),
    .dither_en(dither_en), .n_out(n_out)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // load a configuration, then run len steps against the arithmetic model
  task automatic run_case(input int iv, input int fr, input int md, input int ph,
                          input bit dt, input int len);
    int a1, a2, a3, s, c1, c2, c3, d2, d3, dd3, db, ofs, sum;
    logic [22:0] lf;
    @(negedge clk);
    load = 1'b1; int_word = INT_W'(iv); frac = MOD_W'(fr);
    modulus = MOD_W'(md); phase = MOD_W'(ph); dither_en = dt;
    @(negedge clk);
    load = 1'b0;
    chk(int'(n_out) == iv, "R2 load output", int'(n_out), iv);
    // scramble the live configuration inputs (R10)
    int_word = INT_W'(iv + 9); frac = MOD_W'((fr + 1) % md);
    modulus = MOD_W'(md + 3); phase = MOD_W'(ph + 1); dither_en = ~dt;
    a1 = ph % md; a2 = 0; a3 = 0; d2 = 0; d3 = 0; dd3 = 0; sum = 0;
    lf = 23'h02A5A5;
    for (int k = 0; k < len; k++) begin
      db = dt ? int'(lf[22]) : 0;
      lf = {lf[21:0], lf[22] ^ lf[17]};
      s = a1 + fr + db; c1 = (s >= md) ? 1 : 0; a1 = s - c1 * md;
      s = a2 + a1;      c2 = (s >= md) ? 1 : 0; a2 = s - c2 * md;
      s = a3 + a2;      c3 = (s >= md) ? 1 : 0; a3 = s - c3 * md;
      ofs = c1 + c2 - d2 + c3 - 2 * d3 + dd3;
      dd3 = d3; d3 = c3; d2 = c2;
      @(negedge clk);
      last_seq[k] = int'(n_out);
      sum += int'(n_out) - iv;
      chk(int'(n_out) == iv + ofs, dt ? "R9 dithered step" : "R3/R10 step",
          int'(n_out), iv + ofs);
      chk(int'(n_out) >= iv - 3 && int'(n_out) <= iv + 4, "R7 range", int'(n_out), iv);
    end
    if (!dt) begin
      int err;
      err = sum * md - len * fr;
      if (err < 0) err = -err;
      chk(err < 4 * md, "R8 average", sum, (len * fr) / md);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int mods [3] = '{5, 7, 16};
    int diffs;
    rst_n = 1'b0; load = 1'b0; int_word = '0; frac = '0;
    modulus = 12'd1; phase = '0; dither_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: idle output before any load
    chk(n_out == '0, "R1 reset", int'(n_out), 0);
    int_word = 8'd77; frac = 12'd3; modulus = 12'd9;
    repeat (5) @(negedge clk);
    chk(n_out == '0, "R1 idle without load", int'(n_out), 0);

    // R3 sweep over all fractions and three seeds
    foreach (mods[m]) begin
      for (int fr = 0; fr < mods[m]; fr++) begin
        run_case(40, fr, mods[m], 0, 1'b0, 2 * mods[m] + 6);
        run_case(40, fr, mods[m], mods[m] - 1, 1'b0, 2 * mods[m] + 6);
        run_case(40, fr, mods[m], mods[m] + 2, 1'b0, 2 * mods[m] + 6);
      end
    end

    // R6: zero fraction and seed give a constant output
    run_case(3, 0, 16, 0, 1'b0, 40);
    for (int k = 0; k < 40; k++)
      chk(last_seq[k] == 3, "R6 constant", last_seq[k], 3);

    // R4: seed and seed+MOD give the same sequence
    run_case(100, 5, 13, 3, 1'b0, 60);
    for (int k = 0; k < 60; k++) seq_a[k] = last_seq[k];
    run_case(100, 5, 13, 16, 1'b0, 60);
    for (int k = 0; k < 60; k++)
      chk(last_seq[k] == seq_a[k], "R4 seed wrap", last_seq[k], seq_a[k]);

    // R5: exact reload reproduces the sequence
    run_case(100, 5, 13, 3, 1'b0, 60);
    for (int k = 0; k < 60; k++)
      chk(last_seq[k] == seq_a[k], "R5 repeat", last_seq[k], seq_a[k]);

    // R9: dither follows the model and changes the sequence
    run_case(60, 5, 16, 0, 1'b0, 100);
    for (int k = 0; k < 100; k++) seq_b[k] = last_seq[k];
    run_case(60, 5, 16, 0, 1'b1, 100);
    diffs = 0;
    for (int k = 0; k < 100; k++) if (last_seq[k] != seq_b[k]) diffs++;
    chk(diffs > 0, "R9 dither changes sequence", diffs, 1);

    // large modulus, R8 over a long run, with and without dither
    run_case(200, 1234, 4095, 777, 1'b0, 300);
    run_case(200, 1234, 4095, 777, 1'b1, 300);
    run_case(250, 4094, 4095, 4000, 1'b0, 300);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule